// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked system read and write a 1M x 8 asynchronous static RAM. A host starts an access by raising `req` with an address, write data and a write flag, and keeps them steady until `rdy` pulses for one cycle. For a read, the returned byte is on `rdata` in the same cycle as that pulse. The memory side drives a 20-bit address, a low-active and a high-active chip enable, write enable and output enable. The data bus is split into output data, input data and a drive enable so that the tristate pad can sit outside the block.

All strobe lengths are whole clock cycles. Each one is computed from a clock-period parameter by dividing the minimum time by the period and rounding up. While the controller is idle the memory is deselected through the low-active enable only. Raising `sleep` while idle pulls the high-active enable low, which puts the memory in data-retention standby. When `sleep` drops, the controller waits one full read-cycle time before it starts any access.

Top module: `sram_async_ctrl`

## Requirements
- R1: While `rst_n` is low, `rdy` is 0, `mem_ce1_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_ce2` is 1 and `mem_dq_oe` is 0.
- R2: The memory is selected (`mem_ce1_n`=0 with `mem_ce2`=1) only during an access. When idle, `mem_ce1_n`=1 and `mem_ce2`=1. `mem_ce1_n` is never 0 while `mem_ce2` is 0.
- R3: A write lasts NW = max(ceil(T_WC/CLK), ceil(T_PWE/CLK)+2) cycles. `mem_we_n` is high in the first cycle, then low for exactly ceil(T_PWE/CLK) cycles, then high again. `mem_dq_oe`=1 and `mem_oe_n`=1 hold for the whole write.
- R4: A read lasts NR = ceil(T_RC/CLK) cycles, with `mem_we_n`=1 and `mem_dq_oe`=0. `mem_oe_n` is high in the first cycle and low in the remaining NR-1 cycles. `mem_oe_n` is never low while `mem_dq_oe` is 1.
- R5: A read returns, on `rdata`, the byte last written to the same 20-bit address. The byte is sampled from `mem_dq_in` at the clock edge that ends the read.
- R6: `mem_addr` holds the accepted address and does not change while the memory is selected.
- R7: `req` is taken only when idle. `rdy` is a one-cycle pulse. With `req` raised before clock edge E0, `rdy` is high in the cycle after edge E0+NW for a write and after edge E0+NR for a read.
- R8: With `sleep`=1 and no `req`, an idle controller drives `mem_ce2`=0 and `mem_ce1_n`=1, and it starts no access while `sleep` stays high.
- R9: After `sleep` falls, `mem_ce2` returns to 1 at once. The first access is selected no sooner than NR+1 cycles after the edge that sees `sleep` low.
- R10: With the defaults (CLK=10, T_RC=45, T_PWE=35, T_WC=45), NR=5, the write pulse is 4 cycles and NW=6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access request, held until `rdy` |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 20 | Access address |
| wdata | input | 8 | Write data |
| sleep | input | 1 | Request for data-retention standby |
| rdy | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read data |
| mem_addr | output | 20 | Memory address |
| mem_ce1_n | output | 1 | Chip enable, active low |
| mem_ce2 | output | 1 | Chip enable, active high |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Data to the pad |
| mem_dq_in | input | 8 | Data from the pad |
| mem_dq_oe | output | 1 | Pad drive enable |

## Verification
The bench sweeps 64 scattered addresses, writing every one and then reading every one back, and times each strobe against the cycle counts it computes itself.

- A write pulse that is one cycle short or long shows up as a wrong low-count on `mem_we_n`.
- Output enable dropping in the first read cycle would overlap a released pad driver and is caught.
- A controller that skips the retention recovery selects the memory early after `sleep` falls.
- A controller that forgets to pull `mem_ce2` low during standby leaves the memory out of retention.
- Wrong sampling or a mixed-up address path returns bytes that do not match the model.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int AW       = 20,
  parameter int DW       = 8,
  parameter int CLK_NS   = 10,
  parameter int T_RC_NS  = 45,
  parameter int T_WC_NS  = 45,
  parameter int T_PWE_NS = 35
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          sleep,
  output logic          rdy,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce1_n,
  output logic          mem_ce2,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  input  logic [DW-1:0] mem_dq_in,
  output logic          mem_dq_oe
);
  localparam int NR   = (T_RC_NS + CLK_NS - 1) / CLK_NS;
  localparam int NWC  = (T_WC_NS + CLK_NS - 1) / CLK_NS;
  localparam int NPW  = (T_PWE_NS + CLK_NS - 1) / CLK_NS;
  localparam int NW   = (NWC > NPW + 2) ? NWC : NPW + 2;
  localparam int NMAX = (NW > NR) ? NW : NR;
  localparam int CW   = $clog2(NMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WR, S_SLP, S_RCV} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      rdy   <= 1'b0;
      rdata <= '0;
      a_q   <= '0;
      d_q   <= '0;
    end else begin
      rdy <= 1'b0;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (req) begin
            a_q <= addr;
            d_q <= wdata;
            st  <= wr ? S_WR : S_RD;
          end else if (sleep) begin
            st <= S_SLP;
          end
        end
        S_RD: begin
          if (cnt == CW'(NR - 1)) begin
            rdata <= mem_dq_in;
            rdy   <= 1'b1;
            st    <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        S_WR: begin
          if (cnt == CW'(NW - 1)) begin
            rdy <= 1'b1;
            st  <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        S_SLP: begin
          cnt <= '0;
          if (!sleep) st <= S_RCV;
        end
        S_RCV: begin
          if (cnt == CW'(NR - 1)) st <= S_IDLE;
          else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_addr   = a_q;
  assign mem_dq_out = d_q;
  assign mem_ce1_n  = !(st == S_RD || st == S_WR);
  assign mem_ce2    = (st != S_SLP);
  assign mem_we_n   = !(st == S_WR && cnt >= CW'(1) && cnt <= CW'(NPW));
  assign mem_oe_n   = !(st == S_RD && cnt != '0);
  assign mem_dq_oe  = (st == S_WR);
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int AW       = 20,
  parameter int CLK_NS   = 10,
  parameter int T_RC_NS  = 45,
  parameter int T_PWE_NS = 35
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rdy,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce1_n,
  input logic          mem_ce2,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          mem_dq_oe
);
  localparam int NR  = (T_RC_NS + CLK_NS - 1) / CLK_NS;
  localparam int NPW = (T_PWE_NS + CLK_NS - 1) / CLK_NS;

  int lowcnt;
  int rcvcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowcnt <= 0;
      rcvcnt <= NR + 1;
    end else begin
      lowcnt <= mem_we_n ? 0 : lowcnt + 1;
      if (!mem_ce2) rcvcnt <= 0;
      else if (rcvcnt < NR + 1) rcvcnt <= rcvcnt + 1;
    end
  end

  a_r2_select_legal: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce1_n |-> mem_ce2);
  a_r3_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> lowcnt == NPW);
  a_r3_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_ce1_n));
  a_r4_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr));
  a_r7_rdy_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |=> !rdy);
  a_r9_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce1_n |-> rcvcnt > NR);
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .AW(AW), .CLK_NS(CLK_NS), .T_RC_NS(T_RC_NS), .T_PWE_NS(T_PWE_NS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rdy(rdy), .mem_addr(mem_addr),
  .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sim_sram_async_ctrl.sv
module sim_sram_async_ctrl;
  localparam int TCK = 10;
  localparam int NR  = (45 + TCK - 1) / TCK;
  localparam int NP  = (35 + TCK - 1) / TCK;
  localparam int NW  = (NR > NP + 2) ? NR : NP + 2;

  logic clk = 0, rst_n = 0, req = 0, wr = 0, sleep = 0;
  logic [19:0] addr = '0;
  logic [7:0] wdata = '0, mem_dq_in;
  logic rdy, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0] rdata, mem_dq_out;
  logic [19:0] mem_addr;
  int total = 0, bad = 0;
  logic [7:0] mdl [int];

  always #(TCK/2) clk = ~clk;

  sram_async_ctrl #(.CLK_NS(TCK)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .sleep(sleep), .rdy(rdy), .rdata(rdata), .mem_addr(mem_addr),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
    .mem_dq_oe(mem_dq_oe));

  always @(posedge mem_we_n)
    if (rst_n && !mem_ce1_n && mem_ce2) mdl[int'(mem_addr)] = mem_dq_out;

  assign mem_dq_in = (!mem_ce1_n && mem_ce2 && mem_we_n && !mem_oe_n &&
                      mdl.exists(int'(mem_addr))) ? mdl[int'(mem_addr)] : 8'h5A;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [19:0] a, input logic [7:0] d,
                        output logic [7:0] q);
    int n = 0, we_lo = 0, oe_lo = 0, sel = 0, misc = 0, first_we = -1, first_oe = -1;
    @(negedge clk);
    req = 1; wr = w; addr = a; wdata = d;
    do begin
      @(negedge clk);
      n++;
      if (!mem_ce1_n) begin
        sel++;
        if (mem_addr != a || !mem_ce2) misc++;
        if (!mem_we_n && first_we < 0) first_we = sel;
        if (!mem_oe_n && first_oe < 0) first_oe = sel;
        if (w && (!mem_dq_oe || !mem_oe_n || mem_dq_out != d)) misc++;
        if (!w && (mem_dq_oe || !mem_we_n)) misc++;
      end
      if (!mem_we_n) we_lo++;
      if (!mem_oe_n) oe_lo++;
    end while (!rdy && n < 40);
    q = rdata;
    req = 0;
    @(negedge clk);
    if (rdy) misc++;
    if (w) begin
      chk("R7/R10 write latency", n, NW + 1);
      chk("R3 we low cycles", we_lo, NP);
      chk("R3 we first low", first_we, 2);
      chk("R3 write length", sel, NW);
    end else begin
      chk("R7/R10 read latency", n, NR + 1);
      chk("R4 oe low cycles", oe_lo, NR - 1);
      chk("R4 oe first low", first_oe, 2);
    end
    chk("R2/R6/R7 strobes and address", misc, 0);
  endtask

  initial begin
    #(200000 * TCK);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] q;
    int n;
    repeat (3) @(negedge clk);
    chk("R1 reset strobes", {rdy, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe}, 6'b011110);
    rst_n = 1;
    @(negedge clk);
    chk("R2 idle enables", {mem_ce1_n, mem_ce2}, 2'b11);
    for (int i = 0; i < 64; i++)
      access(1'b1, 20'((i * 16411 + i * i * 7) & 20'hFFFFF), 8'((i * 37) ^ 8'hC3), q);
    for (int i = 63; i >= 0; i--) begin
      access(1'b0, 20'((i * 16411 + i * i * 7) & 20'hFFFFF), 8'h00, q);
      chk("R5 readback", q, 8'((i * 37) ^ 8'hC3));
    end
    access(1'b1, 20'hFFFFF, 8'h81, q);
    access(1'b1, 20'h00000, 8'h18, q);
    access(1'b0, 20'hFFFFF, 8'h00, q);
    chk("R5 top address", q, 8'h81);
    access(1'b0, 20'h00000, 8'h00, q);
    chk("R5 zero address", q, 8'h18);

    @(negedge clk); sleep = 1;
    repeat (3) @(negedge clk);
    chk("R8 retention enables", {mem_ce1_n, mem_ce2}, 2'b10);
    req = 1; wr = 0; addr = 20'hFFFFF;
    n = 0;
    repeat (6) begin @(negedge clk); if (!mem_ce1_n || mem_ce2) n++; end
    chk("R8 no access in sleep", n, 0);
    sleep = 0;
    n = 0;
    do begin @(negedge clk); n++;
      if (n == 1) chk("R9 ce2 back high", mem_ce2, 1);
    end while (mem_ce1_n && n < 40);
    chk("R9 recovery wait", n, NR + 2);
    do @(negedge clk); while (!rdy);
    chk("R5 read after retention", rdata, 8'h81);
    req = 0;
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule